// File: doc/BRIEF.md
# Configurable Integer ALU Datapath

A combinational arithmetic and logic unit that takes two operands of `WIDTH` bits and a 6-bit function word, and returns one result of `WIDTH` bits. It also returns three condition flags (zero, overflow, negative) taken from its internal adder/subtractor. Five units work in parallel: adder/subtractor, comparator, truth-table logic unit, barrel shifter, and a multiplier that keeps only the low half of the product. A final multiplexer picks one unit's output.

The function word is not an opcode. Its subfields drive the units directly. The top two bits pick the output source. Bit 0 chooses between add and subtract. Bits [2:1] pick the comparison. Bits [1:0] pick the shift kind. The low four bits act as the logic unit's truth table. Every one of the 64 codes gives a defined result. The default `WIDTH` is 32, and any power of two from 4 upward is legal.

Top module: `alu_core`

## Requirements
- R1: `func_i[5:4]` selects the result source: 00 arithmetic, 01 logic unit, 10 shifter, 11 comparator. Every one of the 64 codes yields the selected unit's output.
- R2: `func_i[0]`=0 gives A+B and `func_i[0]`=1 gives A−B, modulo 2^WIDTH. ADD is 0x00 and SUB is 0x01.
- R3: `z_o` is set when the adder output is all zeros, and `n_o` equals its top bit. `v_o` flags two's-complement overflow of the add or subtract. All three flags follow the adder for every code, whichever source is selected.
- R4: In comparator mode, result bit 0 depends on `func_i[2:1]`: 01 gives Z, 10 gives N xor V, 11 gives Z or (N xor V), and 00 gives 0. All upper result bits are zero. CMPEQ is 0x33, CMPLT is 0x35 and CMPLE is 0x37, giving signed A=B, A<B and A≤B.
- R5: In logic mode, result bit i equals `func_i[2*B[i]+A[i]]`. AND is 0x18, OR is 0x1E, XOR is 0x16 and pass-A is 0x1A.
- R6: In shift mode, A is shifted by the low log2(WIDTH) bits of B. `func_i[0]`=0 shifts left with zero fill. `func_i[0]`=1 shifts right, filling with A's top bit when `func_i[1]`=1 and with zeros otherwise. SHL is 0x20, SHR is 0x21 and SRA is 0x23.
- R7: When `func_i[5:4]`=00 and `func_i[1]`=1, the result is the low WIDTH bits of A×B (MUL is 0x02). This value is the same for unsigned and two's-complement operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_i | input | 6 | Function word |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B; its low bits also give the shift amount |
| result_o | output | WIDTH | Selected unit's output |
| z_o | output | 1 | Adder output is zero |
| v_o | output | 1 | Adder signed overflow |
| n_o | output | 1 | Adder output is negative |

## Verification
The embedded checks are immediate assertions on a purely combinational block. They assume that the operands and function word hold steady while the checked outputs are read. The bench meets this by changing inputs only on the falling clock edge and sampling 2 ns later. The assertions place no restriction on the function code or operand values. The bench therefore sweeps all 64 codes and every operand pair at WIDTH=4. At WIDTH=32 it uses sign-boundary corner values, powers-of-two multiply patterns and random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FUNC_W = 6;

  typedef enum logic [1:0] {
    SRC_ARITH = 2'b00,
    SRC_LOGIC = 2'b01,
    SRC_SHIFT = 2'b10,
    SRC_CMP   = 2'b11
  } alu_src_e;

  typedef enum logic [1:0] {
    CMP_NONE = 2'b00,
    CMP_EQ   = 2'b01,
    CMP_LT   = 2'b10,
    CMP_LE   = 2'b11
  } cmp_kind_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         z_o,
  output logic         v_o,
  output logic         n_o
);
  logic [W-1:0] xb;

  assign xb    = b_i ^ {W{sub_i}};
  assign sum_o = a_i + xb + {{(W-1){1'b0}}, sub_i};
  assign z_o   = ~|sum_o;
  assign n_o   = sum_o[W-1];
  assign v_o   = (a_i[W-1] == xb[W-1]) && (sum_o[W-1] != a_i[W-1]);

  always_comb begin
    // R3
    if (sub_i && (a_i == b_i)) sub_eq_zero_chk: assert (z_o && !v_o);
    // R3
    if (!sub_i && (a_i[W-1] != b_i[W-1])) mixed_sign_add_chk: assert (!v_o);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [3:0]   tt_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[i] = tt_i[{b_i[i], a_i[i]}];
  end

  always_comb begin
    // R5
    if (tt_i == 4'b1010) pass_a_chk: assert (y_o == a_i);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          right_i,
  input  logic          arith_i,
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  y_o
);
  logic [W-1:0] a_rev, pre, post_rev;
  logic [W-1:0] stage [SW+1];
  logic         fill;

  assign fill = right_i & arith_i & a_i[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i]    = a_i[W-1-i];
    assign post_rev[i] = stage[SW][W-1-i];
  end

  // right shift reuses the left cascade on bit-reversed data
  assign pre      = right_i ? a_rev : a_i;
  assign stage[0] = pre;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][W-1-SH:0], {SH{fill}}} : stage[k];
  end

  assign y_o = right_i ? post_rev : stage[SW];

  always_comb begin
    // R6
    if (amt_i == '0) zero_amt_chk: assert (y_o == a_i);
  end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  logic [W-1:0] acc [W+1];

  assign acc[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_row
    assign acc[i+1] = acc[i] + ((a_i << i) & {W{b_i[i]}});
  end
  assign p_o = acc[W];

  always_comb begin
    // R7
    if (b_i == W'(1)) mul_by_one_chk: assert (p_o == a_i);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SW = $clog2(WIDTH)
) (
  input  logic [FUNC_W-1:0] func_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              z_o,
  output logic              v_o,
  output logic              n_o
);
  logic [WIDTH-1:0] sum, logic_y, shift_y, mul_y, cmp_y, arith_y;
  logic             zf, vf, nf, lt, cmp_bit;
  alu_src_e         src;
  cmp_kind_e        ck;

  alu_addsub #(.W(WIDTH)) u_addsub (
    .sub_i(func_i[0]), .a_i(a_i), .b_i(b_i),
    .sum_o(sum), .z_o(zf), .v_o(vf), .n_o(nf)
  );

  alu_logic #(.W(WIDTH)) u_logic (
    .tt_i(func_i[3:0]), .a_i(a_i), .b_i(b_i), .y_o(logic_y)
  );

  alu_shift #(.W(WIDTH)) u_shift (
    .right_i(func_i[0]), .arith_i(func_i[1]), .a_i(a_i),
    .amt_i(b_i[SW-1:0]), .y_o(shift_y)
  );

  alu_mul #(.W(WIDTH)) u_mul (
    .a_i(a_i), .b_i(b_i), .p_o(mul_y)
  );

  // compare from flags; N^V is the late path, kept shallow
  assign lt = nf ^ vf;
  assign ck = cmp_kind_e'(func_i[2:1]);
  always_comb begin
    unique case (ck)
      CMP_EQ:  cmp_bit = zf;
      CMP_LT:  cmp_bit = lt;
      CMP_LE:  cmp_bit = zf | lt;
      default: cmp_bit = 1'b0;
    endcase
  end
  assign cmp_y = {{(WIDTH-1){1'b0}}, cmp_bit};

  assign arith_y = func_i[1] ? mul_y : sum;
  assign src     = alu_src_e'(func_i[5:4]);

  always_comb begin
    unique case (src)
      SRC_ARITH: result_o = arith_y;
      SRC_LOGIC: result_o = logic_y;
      SRC_SHIFT: result_o = shift_y;
      default:   result_o = cmp_y;
    endcase
  end

  assign z_o = zf;
  assign v_o = vf;
  assign n_o = nf;

  always_comb begin
    // R4
    if (src == SRC_CMP) cmp_upper_zero_chk: assert (result_o[WIDTH-1:1] == '0);
    // R2
    if (func_i[5:4] == 2'b00 && !func_i[1] && result_o == '0) arith_zero_flag_chk: assert (z_o);
  end
endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [5:0]  f;
  logic [31:0] a32, b32, r32;
  logic        z32, v32, n32;
  logic [3:0]  a4, b4, r4;
  logic        z4, v4, n4;

  alu_core #(.WIDTH(32)) dut_i (
    .func_i(f), .a_i(a32), .b_i(b32), .result_o(r32),
    .z_o(z32), .v_o(v32), .n_o(n32)
  );

  alu_core #(.WIDTH(4)) dut_small_i (
    .func_i(f), .a_i(a4), .b_i(b4), .result_o(r4),
    .z_o(z4), .v_o(v4), .n_o(n4)
  );

  function automatic logic [34:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b, int n);
    logic [63:0] m, ua, ub, sum, res, mul;
    longint sa, sb, st, mx, mn;
    logic zf, nf, vf, cb;
    int amt;
    m  = (n == 32) ? 64'hFFFF_FFFF : ((64'd1 << n) - 1);
    ua = {32'd0, a} & m;
    ub = {32'd0, b} & m;
    sum = fn[0] ? ((ua - ub) & m) : ((ua + ub) & m);
    sa = ua[n-1] ? longint'(ua) - (longint'(1) << n) : longint'(ua);
    sb = ub[n-1] ? longint'(ub) - (longint'(1) << n) : longint'(ub);
    st = fn[0] ? sa - sb : sa + sb;
    mx = (longint'(1) << (n-1)) - 1;
    mn = -(longint'(1) << (n-1));
    vf = (st > mx) || (st < mn);
    zf = (sum == 0);
    nf = sum[n-1];
    mul = (ua * ub) & m;
    case (fn[5:4])
      2'b00: res = fn[1] ? mul : sum;
      2'b01: begin
        res = 0;
        for (int i = 0; i < n; i++) res[i] = fn[{ub[i], ua[i]}];
      end
      2'b10: begin
        amt = int'(ub % n);
        if (!fn[0]) res = (ua << amt) & m;
        else if (fn[1] && ua[n-1]) res = (ua >> amt) | (m & ~(m >> amt));
        else res = ua >> amt;
      end
      default: begin
        case (fn[2:1])
          2'b01: cb = zf;
          2'b10: cb = nf ^ vf;
          2'b11: cb = zf | (nf ^ vf);
          default: cb = 1'b0;
        endcase
        res = {63'd0, cb};
      end
    endcase
    return {zf, vf, nf, res[31:0]};
  endfunction

  function automatic string req_of(logic [5:0] fn);
    case (fn[5:4])
      2'b00: return fn[1] ? "R7" : "R2";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic [34:0] act, logic [34:0] exp, logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s f=%h a=%h b=%h actual={zvn=%b res=%h} expected={zvn=%b res=%h}",
               req, fn, a, b, act[34:32], act[31:0], exp[34:32], exp[31:0]);
    end
  endtask

  task automatic run32(string req, logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    f = fn; a32 = a; b32 = b;
    #2;
    chk(req, {z32, v32, n32, r32}, ref_alu(fn, a, b, 32), fn, a, b);
  endtask

  task automatic run4(string req, logic [5:0] fn, logic [3:0] a, logic [3:0] b);
    @(negedge clk);
    f = fn; a4 = a; b4 = b;
    #2;
    chk(req, {z4, v4, n4, 28'd0, r4}, ref_alu(fn, {28'd0, a}, {28'd0, b}, 4), fn, {28'd0, a}, {28'd0, b});
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
  end

  logic [5:0]  ops [13];
  logic [31:0] corners [5];

  initial begin
    ops = '{6'h00, 6'h01, 6'h18, 6'h1E, 6'h16, 6'h1A, 6'h20, 6'h21, 6'h23, 6'h33, 6'h35, 6'h37, 6'h02};
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};
    f = '0; a32 = '0; b32 = '0; a4 = '0; b4 = '0;

    // R3 idle state: zero operands, ADD -> zero result, Z set
    #2;
    total++;
    if ({z32, v32, n32, r32} !== {3'b100, 32'd0}) begin
      bad++;
      $display("FAIL R3 idle actual=%b_%h expected=100_00000000", {z32, v32, n32}, r32);
    end

    // R1 all 64 codes, every operand pair at WIDTH=4
    for (int fi = 0; fi < 64; fi++)
      for (int ai = 0; ai < 16; ai++)
        for (int bi = 0; bi < 16; bi++)
          run4(req_of(6'(fi)), 6'(fi), 4'(ai), 4'(bi));

    // R2 R3 R4 R5 R6 R7 corner operands at WIDTH=32
    for (int o = 0; o < 13; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run32(req_of(ops[o]), ops[o], corners[i], corners[j]);

    // R3 overflow edges
    run32("R3", 6'h00, 32'h7FFF_FFFF, 32'h1);
    run32("R3", 6'h01, 32'h8000_0000, 32'h1);
    // R4 signed order across sign boundary
    run32("R4", 6'h35, 32'h8000_0000, 32'h7FFF_FFFF);
    run32("R4", 6'h37, 32'h7FFF_FFFF, 32'h7FFF_FFFF);

    // R7 multiply patterns
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        run32("R7", 6'h02, corners[i], corners[j]);
    for (int i = 0; i < 32; i++) begin
      run32("R7", 6'h02, 32'd1 << i, 32'd1);
      run32("R7", 6'h02, 32'hFFFF_FFFF, 32'd1 << i);
      run32("R7", 6'h02, 32'd3 << i, 32'd3);
    end

    // R6 every shift amount with a sign-set pattern
    for (int s = 0; s < 32; s++) begin
      run32("R6", 6'h20, 32'h9234_5679, 32'(s));
      run32("R6", 6'h21, 32'h9234_5679, 32'(s));
      run32("R6", 6'h23, 32'h9234_5679, 32'(s) | 32'hFFFF_FFE0);
    end

    // R1 random operands over listed codes
    for (int k = 0; k < 200; k++)
      for (int o = 0; o < 13; o++)
        run32(req_of(ops[o]), ops[o], $urandom, $urandom);

    summary();
  end
endmodule